// File: doc/BRIEF.md
# Serial Shadowed-RAM Command Slave

This block is the slave side of a three-wire serial port in front of a small memory. The memory holds a working RAM array and a shadow array of the same size. A host raises the chip enable and clocks 8-bit instructions in on the serial data input, most significant bit first, one bit per rising edge of the serial clock. The instructions write a RAM word, read a RAM word, copy the shadow array into RAM (recall), and copy RAM into the shadow array (store). Other instructions set or clear the protection latches that guard a store.

All serial pins are sampled on the system clock, and the block detects serial-clock edges by comparing each sample with the one before. A store only goes through once software has set the write-enable latch and a recall has set the previous-recall latch. After reset the block runs a power-up recall window of a parameterised number of clocks. During that window it ignores every command, and when the window closes it copies the shadow array into RAM without setting the previous-recall latch. A supply-fail input starts an automatic store once the autostore latch has been set.

Top module: `nvram_serial_slave`

## Requirements
- R1: While reset is held and afterwards, `do_oe` stays low until a read reaches its data phase. POR_CYCLES clocks after reset is released, RAM word i holds the shadow reset pattern 0xC3A0 XOR (i * 0x0101). The write-enable, autostore-enable and previous-recall latches start cleared.
- R2: Write is 1AAAA011 (start bit, 4-bit address, code 011) followed by 16 data bits, all MSB first. The word is committed to RAM when CE goes low.
- R3: If CE falls after k data bits with 1 <= k <= 15, the addressed word becomes those k bits right-aligned with zeros above them. If CE falls with no data bits, the word is unchanged.
- R4: If more than 16 data bits are clocked in, shifting continues and the word keeps the last 16 bits received.
- R5: Read is 1AAAA11x, and its eighth bit has no effect. Data bit 15 appears on `do_o`, with `do_oe` high, at the falling edge of the 8th SK clock and holds through the 9th clock. Each following bit changes at rising edges 10 to 24. `do_oe` drops at rising edge 25.
- R6: `do_oe` is low outside the read data phase, and it is low in the clock after CE is sampled low.
- R7: Store (10000001) copies RAM into the shadow array only when both the write-enable and the previous-recall latches are set. Otherwise the shadow array is unchanged.
- R8: 10000100 sets the write-enable latch and 10000000 clears it.
- R9: Recall (10000101) copies the shadow array into RAM and sets the previous-recall latch. The power-up recall does not set that latch.
- R10: A rising edge on `hw_recall` acts like the recall instruction.
- R11: 10000010 sets the autostore latch. A rising edge on `pwr_fail` then stores RAM into the shadow array if the autostore, write-enable and previous-recall latches are all set, and does nothing otherwise.
- R12: CE low clears the instruction shifter. A partly shifted instruction has no effect, and the next instruction after CE rises is decoded from its first bit.
- R13: During the power-up window, serial instructions, `hw_recall` and `pwr_fail` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low reset; models power-up |
| ce | input | 1 | Chip enable; high frames one instruction |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in, MSB first |
| pwr_fail | input | 1 | Supply-fail indication; a rising edge requests an autostore |
| hw_recall | input | 1 | Rising edge requests a recall |
| do_o | output | 1 | Serial data out during the read data phase |
| do_oe | output | 1 | High while `do_o` is driven; low means high impedance |

## Verification
The bench builds the block with DATA_W=16 and POR_CYCLES=400. The longer window lets a complete 24-clock write, a write-enable instruction and a `hw_recall` pulse all land inside the power-up interval. That makes the ignore rule and the unset previous-recall latch after power-up observable: a store attempted right after the window must leave the shadow array unchanged. With 16-bit words, a write cut after 5 bits, a write stretched to 20 bits, and random lengths from 1 to 24 bits can all be compared against the bench's own model.

// File: rtl/nvram_pkg.sv
package nvram_pkg;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 4;
    localparam int WORDS  = 1 << ADDR_W;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDS,
        OP_RCL,
        OP_STO,
        OP_ENAS
    } op_e;

    typedef enum logic [2:0] {
        FE_SKIP,
        FE_CMD,
        FE_WDATA,
        FE_RLOAD,
        FE_RDATA
    } fe_state_e;

    // low three bits of the control instructions (address field all zero)
    localparam logic [2:0] CTL_WREN = 3'b100;
    localparam logic [2:0] CTL_WRDS = 3'b000;
    localparam logic [2:0] CTL_RCL  = 3'b101;
    localparam logic [2:0] CTL_STO  = 3'b001;
    localparam logic [2:0] CTL_ENAS = 3'b010;
    localparam logic [2:0] CODE_WR  = 3'b011;
endpackage

// File: rtl/nvram_sys_ctl.sv
module nvram_sys_ctl #(
    parameter int POR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail_i,
    input  logic hw_recall_i,
    output logic por_busy_o,
    output logic por_recall_o,
    output logic fail_evt_o,
    output logic hrcl_evt_o
);
    localparam int CNT_W = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pf_prev;
        logic             hr_prev;
    } sys_t;

    sys_t q, n;

    assign por_busy_o   = (q.cnt != CNT_W'(POR_CYCLES));
    assign por_recall_o = (q.cnt == CNT_W'(POR_CYCLES - 1));
    assign fail_evt_o   = pwr_fail_i  & ~q.pf_prev & ~por_busy_o;
    assign hrcl_evt_o   = hw_recall_i & ~q.hr_prev & ~por_busy_o;

    always_comb begin
        n         = q;
        n.pf_prev = pwr_fail_i;
        n.hr_prev = hw_recall_i;
        if (por_busy_o) begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    // R1: once the power-up window has closed it stays closed
    p_window_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_busy_o |=> !por_busy_o);
endmodule

// File: rtl/nvram_frontend.sv
module nvram_frontend
    import nvram_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_busy_i,
    input  logic              ce,
    input  logic              sk,
    input  logic              di,
    input  logic [DATA_W-1:0] rd_word_i,
    output op_e               op_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              do_o,
    output logic              do_oe_o
);
    localparam int BCNT_W = $clog2(CMD_W + 1);
    localparam int RCNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              sk_prev;
        fe_state_e         state;
        logic [BCNT_W-1:0] bcnt;
        logic [CMD_W-2:0]  cmd_sr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wsr;
        logic              got;
        logic [RCNT_W-1:0] rcnt;
        logic [DATA_W-1:0] dsr;
        logic              oe;
    } fe_t;

    fe_t q, n;
    logic sk_rise, sk_fall, sk_edge;
    logic [CMD_W-1:0] full;

    assign sk_rise   = ce & sk & ~q.sk_prev;
    assign sk_fall   = ce & ~sk & q.sk_prev;
    assign sk_edge   = sk ^ q.sk_prev;
    assign full      = {q.cmd_sr, di};
    assign wr_addr_o = q.addr;
    assign wr_data_o = q.wsr;
    assign rd_addr_o = q.addr;
    assign do_o      = q.dsr[DATA_W-1];
    assign do_oe_o   = q.oe;

    always_comb begin
        n         = q;
        op_o      = OP_NONE;
        wr_en_o   = 1'b0;
        n.sk_prev = sk;
        if (por_busy_i) begin
            n.state = FE_SKIP;
            n.bcnt  = '0;
            n.oe    = 1'b0;
        end else if (!ce) begin
            if (q.state == FE_WDATA && q.got) begin
                wr_en_o = 1'b1;
            end
            n.state = FE_CMD;
            n.bcnt  = '0;
            n.got   = 1'b0;
            n.rcnt  = '0;
            n.oe    = 1'b0;
        end else begin
            case (q.state)
                FE_CMD: begin
                    if (sk_rise) begin
                        n.cmd_sr = full[CMD_W-2:0];
                        n.bcnt   = q.bcnt + 1'b1;
                        if (q.bcnt == BCNT_W'(CMD_W - 1)) begin
                            n.addr  = full[CMD_W-2 -: ADDR_W];
                            n.state = FE_SKIP;
                            if (full[CMD_W-1]) begin
                                if (full[2:1] == 2'b11) begin
                                    n.state = FE_RLOAD;
                                end else if (full[2:0] == CODE_WR) begin
                                    n.state = FE_WDATA;
                                    n.wsr   = '0;
                                    n.got   = 1'b0;
                                end else if (full[CMD_W-2 -: ADDR_W] == '0) begin
                                    case (full[2:0])
                                        CTL_WREN: op_o = OP_WREN;
                                        CTL_WRDS: op_o = OP_WRDS;
                                        CTL_RCL:  op_o = OP_RCL;
                                        CTL_STO:  op_o = OP_STO;
                                        CTL_ENAS: op_o = OP_ENAS;
                                        default:  op_o = OP_NONE;
                                    endcase
                                end
                            end
                        end
                    end
                end
                FE_WDATA: begin
                    if (sk_rise) begin
                        n.wsr = {q.wsr[DATA_W-2:0], di};
                        n.got = 1'b1;
                    end
                end
                FE_RLOAD: begin
                    if (sk_fall) begin
                        n.dsr   = rd_word_i;
                        n.oe    = 1'b1;
                        n.rcnt  = '0;
                        n.state = FE_RDATA;
                    end
                end
                FE_RDATA: begin
                    if (sk_rise) begin
                        if (q.rcnt == '0) begin
                            n.rcnt = q.rcnt + 1'b1;
                        end else if (q.rcnt < RCNT_W'(DATA_W)) begin
                            n.dsr  = {q.dsr[DATA_W-2:0], 1'b0};
                            n.rcnt = q.rcnt + 1'b1;
                        end else begin
                            n.oe    = 1'b0;
                            n.state = FE_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= FE_SKIP;
        end else begin
            q <= n;
        end
    end

    // R6: a low chip enable turns the output driver off on the next clock
    p_oe_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> !do_oe_o);
    // R5: the driver only switches on at a falling serial-clock edge
    p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe_o) |-> $past(sk_fall));
    // R5: data out moves only on serial-clock edges
    p_do_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe_o && $past(do_oe_o) && !$past(sk_edge)) |-> $stable(do_o));
endmodule

// File: rtl/nvram_core.sv
module nvram_core
    import nvram_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              por_recall_i,
    input  logic              fail_evt_i,
    input  logic              hrcl_evt_i,
    output logic [DATA_W-1:0] rd_word_o
);
    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] ram;
        logic [WORDS-1:0][DATA_W-1:0] shadow;
        logic                         we;
        logic                         pr;
        logic                         as_en;
    } core_t;

    core_t q, n;
    logic rcl_req, sto_ok, sto_req;

    function automatic core_t reset_value();
        core_t v;
        v = '0;
        for (int i = 0; i < WORDS; i++) begin
            v.shadow[i] = DATA_W'(32'hC3A0 ^ (32'(i) * 32'h0101));
        end
        return v;
    endfunction

    assign rd_word_o = q.ram[rd_addr_i];
    assign rcl_req   = (op_i == OP_RCL) || hrcl_evt_i;
    assign sto_ok    = q.we && q.pr;
    assign sto_req   = sto_ok && ((op_i == OP_STO) || (fail_evt_i && q.as_en));

    always_comb begin
        n = q;
        if (por_recall_i) begin
            n.ram = q.shadow;
        end
        if (rcl_req) begin
            n.ram = q.shadow;
            n.pr  = 1'b1;
        end
        if (sto_req) begin
            n.shadow = q.ram;
        end
        case (op_i)
            OP_WREN: n.we    = 1'b1;
            OP_WRDS: n.we    = 1'b0;
            OP_ENAS: n.as_en = 1'b1;
            default: ;
        endcase
        if (wr_en_i) begin
            n.ram[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= reset_value();
        end else begin
            q <= n;
        end
    end

    // R7: the shadow array only changes after both guard latches were set
    p_store_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.shadow) |-> $past(q.we && q.pr));
    // R9: previous-recall latch rises only from an explicit or pin recall
    p_pr_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pr) |-> $past((op_i == OP_RCL) || hrcl_evt_i));
    // R8: write-disable leaves the write-enable latch cleared
    p_we_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_i == OP_WRDS) |-> !q.we);
endmodule

// File: rtl/nvram_serial_slave.sv
module nvram_serial_slave
    import nvram_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int POR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sk,
    input  logic di,
    input  logic pwr_fail,
    input  logic hw_recall,
    output logic do_o,
    output logic do_oe
);
    logic              por_busy, por_recall, fail_evt, hrcl_evt;
    op_e               op;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_word;

    nvram_sys_ctl #(.POR_CYCLES(POR_CYCLES)) u_sys (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_fail_i   (pwr_fail),
        .hw_recall_i  (hw_recall),
        .por_busy_o   (por_busy),
        .por_recall_o (por_recall),
        .fail_evt_o   (fail_evt),
        .hrcl_evt_o   (hrcl_evt)
    );

    nvram_frontend #(.DATA_W(DATA_W)) u_fe (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_busy_i (por_busy),
        .ce         (ce),
        .sk         (sk),
        .di         (di),
        .rd_word_i  (rd_word),
        .op_o       (op),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_addr_o  (rd_addr),
        .do_o       (do_o),
        .do_oe_o    (do_oe)
    );

    nvram_core #(.DATA_W(DATA_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .por_recall_i (por_recall),
        .fail_evt_i   (fail_evt),
        .hrcl_evt_i   (hrcl_evt),
        .rd_word_o    (rd_word)
    );

    // R13: nothing reaches the data pin while the power-up window is open
    p_por_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        por_busy |-> !do_oe);
    // R13: no RAM write is issued while the power-up window is open
    p_por_no_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        por_busy |-> !wr_en);
endmodule

// File: tb/nvram_serial_slave_bench.sv
module nvram_serial_slave_bench;
    localparam int DW  = 16;
    localparam int POR = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sk = 1'b0, di = 1'b0, pwr_fail = 1'b0, hw_recall = 1'b0;
    logic do_o, do_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] ram_m [16];
    logic [15:0] sh_m  [16];
    bit we_m, pr_m, as_m;

    always #4 clk = ~clk;

    nvram_serial_slave #(.DATA_W(DW), .POR_CYCLES(POR)) u_nvram_serial_slave (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .di(di),
        .pwr_fail(pwr_fail), .hw_recall(hw_recall), .do_o(do_o), .do_oe(do_oe)
    );

    function automatic logic [15:0] init_word(int i);
        return 16'hC3A0 ^ 16'(i * 16'h0101);
    endfunction

    function automatic logic [15:0] exp_wr(logic [63:0] seq, int nd);
        logic [15:0] m;
        m = (nd >= 16) ? 16'hFFFF : 16'((32'd1 << nd) - 1);
        return seq[15:0] & m;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b, output logic lo_do, output logic lo_oe,
                          output logic hi_do, output logic hi_oe);
        di = b;
        sk = 1'b0;
        waitn(2);
        lo_do = do_o; lo_oe = do_oe;
        waitn(1);
        sk = 1'b1;
        waitn(2);
        hi_do = do_o; hi_oe = do_oe;
        waitn(1);
    endtask

    task automatic xfer(input logic [63:0] bits, input int nb,
                        output logic [63:0] lo_do, output logic [63:0] lo_oe,
                        output logic [63:0] hi_do, output logic [63:0] hi_oe);
        @(negedge clk);
        sk = 1'b0; ce = 1'b1;
        waitn(2);
        for (int i = 0; i < nb; i++) begin
            sk_bit(bits[nb-1-i], lo_do[i], lo_oe[i], hi_do[i], hi_oe[i]);
        end
        sk = 1'b0;
        waitn(3);
        ce = 1'b0;
        waitn(4);
    endtask

    task automatic m_store();
        if (we_m && pr_m) for (int i = 0; i < 16; i++) sh_m[i] = ram_m[i];
    endtask

    task automatic m_recall();
        for (int i = 0; i < 16; i++) ram_m[i] = sh_m[i];
        pr_m = 1'b1;
    endtask

    // write: 1AAAA011 then nd data bits (seq holds them, last sent at bit 0)
    task automatic wr(input logic [3:0] a, input logic [63:0] seq, input int nd, input bit model);
        logic [63:0] ld, lo, hd, ho, bits, m;
        m = (nd == 0) ? 64'd0 : ((64'd1 << nd) - 1);
        bits = ({56'd0, 1'b1, a, 3'b011} << nd) | (seq & m);
        xfer(bits, 8 + nd, ld, lo, hd, ho);
        chk("R6 no drive during write", 32'(|(lo | ho)), 32'd0);
        if (model && nd > 0) ram_m[a] = exp_wr(seq, nd);
    endtask

    task automatic ctl(input logic [2:0] c);
        logic [63:0] ld, lo, hd, ho;
        xfer({56'd0, 5'b10000, c}, 8, ld, lo, hd, ho);
    endtask

    task automatic rd(input logic [3:0] a, input logic i0, output logic [15:0] w,
                      output logic [63:0] lo_do, output logic [63:0] lo_oe);
        logic [63:0] hd, ho, expo;
        xfer({39'd0, 1'b1, a, 2'b11, i0, 17'd0}, 25, lo_do, lo_oe, hd, ho);
        for (int k = 0; k < 16; k++) w[15-k] = hd[8+k];
        expo = 64'h0000_0000_00FF_FF00;
        chk("R5 oe window 9..24", 32'(ho[24:0]), 32'(expo[24:0]));
    endtask

    task automatic rdchk(string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] w;
        logic [63:0] ld, lo;
        rd(a, 1'($urandom % 2), w, ld, lo);
        chk(req, {16'd0, w}, {16'd0, exp});
    endtask

    task automatic pulse(input bit which);
        @(negedge clk);
        if (which) pwr_fail = 1'b1; else hw_recall = 1'b1;
        waitn(3);
        pwr_fail = 1'b0; hw_recall = 1'b0;
        waitn(3);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [15:0] w;
        logic [63:0] ld, lo, seq;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin
            sh_m[i] = init_word(i);
            ram_m[i] = init_word(i);
        end
        we_m = 0; pr_m = 0; as_m = 0;

        waitn(3);
        chk("R1 oe low in reset", 32'(do_oe), 32'd0);
        waitn(7);
        rst_n = 1'b1;
        chk("R1 oe low after reset", 32'(do_oe), 32'd0);

        // R13: commands inside the power-up window
        wr(4'd5, 64'hFFFF, 16, 0);
        ctl(3'b100);
        pulse(0);
        pulse(1);
        waitn(POR);

        // R1: power-up recall pattern; R13: write at 5 was ignored
        for (int i = 0; i < 16; i++) rdchk("R1 por pattern", 4'(i), init_word(i));

        // R9: power-up recall leaves previous-recall clear, so store is blocked
        wr(4'd2, 64'h1111, 16, 1);
        ctl(3'b100); we_m = 1;
        ctl(3'b001); m_store();
        ctl(3'b101); m_recall();
        rdchk("R9 por recall no prev-recall", 4'd2, init_word(2));

        // R7: store with both latches set
        wr(4'd2, 64'h5A5A, 16, 1);
        ctl(3'b001); m_store();
        wr(4'd2, 64'h0F0F, 16, 1);
        rdchk("R2 full write", 4'd2, 16'h0F0F);
        ctl(3'b101); m_recall();
        rdchk("R7 stored then recalled", 4'd2, 16'h5A5A);

        // R8: write-disable blocks store
        ctl(3'b000); we_m = 0;
        wr(4'd2, 64'h7777, 16, 1);
        ctl(3'b001); m_store();
        ctl(3'b101); m_recall();
        rdchk("R8 store blocked after disable", 4'd2, 16'h5A5A);

        // R3: partial and empty writes
        wr(4'd7, 64'h1B, 5, 1);
        rdchk("R3 partial 5 bits", 4'd7, 16'h001B);
        wr(4'd7, 64'h0, 0, 1);
        rdchk("R3 zero data bits unchanged", 4'd7, 16'h001B);

        // R4: overlong write keeps last 16 bits
        wr(4'd8, 64'hABCDE, 20, 1);
        rdchk("R4 last 16 bits", 4'd8, 16'hBCDE);

        // R5: detailed timing, both values of I0
        wr(4'd9, 64'h8001, 16, 1);
        rd(4'd9, 1'b0, w, ld, lo);
        chk("R5 I0=0 word", {16'd0, w}, 32'h8001);
        chk("R5 no drive before 8th fall", 32'(lo[7]), 32'd0);
        chk("R5 first bit at 8th fall", {30'd0, lo[8], ld[8]}, {30'd0, 1'b1, 1'b1});
        chk("R5 first bit held to 10th rise", 32'(ld[9]), 32'd1);
        rd(4'd9, 1'b1, w, ld, lo);
        chk("R5 I0=1 word", {16'd0, w}, 32'h8001);

        // R12: aborted instruction then a clean read
        @(negedge clk); ce = 1'b1; waitn(2);
        for (int i = 0; i < 5; i++) begin
            logic a1, a2, a3, a4;
            sk_bit(1'b1, a1, a2, a3, a4);
        end
        sk = 1'b0; waitn(2); ce = 1'b0; waitn(4);
        rdchk("R12 fresh decode after abort", 4'd8, 16'hBCDE);

        // R10: pin recall
        wr(4'd3, 64'hDEAD, 16, 1);
        pulse(0); m_recall();
        rdchk("R10 pin recall", 4'd3, sh_m[3]);

        // R11: autostore needs the autostore latch
        ctl(3'b100); we_m = 1;
        wr(4'd10, 64'h1357, 16, 1);
        pulse(1);
        ctl(3'b101); m_recall();
        rdchk("R11 no autostore without enable", 4'd10, sh_m[10]);
        ctl(3'b010); as_m = 1;
        wr(4'd10, 64'h2468, 16, 1);
        pulse(1); m_store();
        wr(4'd10, 64'h0000, 16, 1);
        ctl(3'b101); m_recall();
        rdchk("R11 autostore", 4'd10, 16'h2468);

        // random mix against the model
        for (int k = 0; k < 120; k++) begin
            int r;
            r = $urandom % 10;
            case (r)
                0, 1, 2, 3: begin
                    seq = {$urandom, $urandom};
                    wr(4'($urandom), seq, 1 + ($urandom % 24), 1);
                end
                4, 5: begin
                    logic [3:0] a;
                    a = 4'($urandom);
                    rdchk("R2 random read", a, ram_m[a]);
                end
                6: if ($urandom % 2) begin ctl(3'b100); we_m = 1; end
                   else begin ctl(3'b000); we_m = 0; end
                7: begin ctl(3'b001); m_store(); end
                8: if ($urandom % 2) begin ctl(3'b101); m_recall(); end
                   else begin pulse(0); m_recall(); end
                default: if ($urandom % 2) begin ctl(3'b010); as_m = 1; end
                   else begin pulse(1); if (as_m) m_store(); end
            endcase
        end
        ctl(3'b101); m_recall();
        for (int i = 0; i < 16; i++) rdchk("R7 final shadow", 4'(i), sh_m[i]);

        done = 1'b1;
        report();
    end
endmodule